// File: doc/BRIEF.md
# SPI Target with Shared-Pointer Circular Buffers

This block is an SPI target for mode 0 links (clock idles low, data sampled on the rising SCLK edge and changed on the falling edge, most significant bit first). Each byte received on MOSI lands in a 64-byte circular receive buffer. Each byte sent on MISO comes from a 64-byte circular transmit buffer. One position pointer serves both buffers. The byte driven out is always the one at the offset where the incoming byte will be stored, so local logic can prepare replies ahead of the controller.

SCLK, chip select and MOSI come into the system clock domain through two-flop synchronisers. The design assumes SCLK runs at no more than one eighth of the system clock. A small register port gives local logic four things:
- read access to the receive buffer,
- write access to the transmit buffer,
- a read of the current position,
- a control register holding the enable bit and three event masks.

Three events are reported:
- the pointer reaching the half point,
- the pointer wrapping to zero,
- chip select being released during a transfer.

Each event is cleared by writing one to its status bit. The interrupt is the OR of the enabled, set bits.

The engine has three named states:
- `ST_OFF`: the block is disabled.
- `ST_IDLE`: enabled, chip select high.
- `ST_XFER`: chip select low.

Its transitions are:
- `ST_OFF` to `ST_IDLE` when enable is set.
- `ST_IDLE` to `ST_XFER` when synchronised chip select falls. The transmit shifter loads from the transmit buffer on this transition.
- `ST_XFER` to `ST_IDLE` when chip select rises. This raises the end event and discards any partial byte.
- Any state to `ST_OFF` when enable is cleared.

Top module: `spi_circ_target`

## Requirements
- R1: After reset the control, position and status registers read 0, irq_o is 0 and miso_oe_o is 0.
- R2: In `ST_XFER`, MISO shows bit 7 of the byte at the current position from the moment the transfer starts. It shifts left one bit on each falling SCLK edge and loads the next byte on the falling edge that follows a completed byte.
- R3: MOSI is sampled on each rising SCLK edge, most significant bit first. Each completed byte is stored in the receive buffer at the current position, and the position then advances by exactly one.
- R4: The position wraps from 63 to 0, and later bytes overwrite earlier ones.
- R5: Status bit 0 (half) is set when the position becomes 32. Status bit 1 (full) is set when the position wraps to 0.
- R6: Status bit 2 (end) is set when chip select is released while in `ST_XFER`.
- R7: Writing 1 to a status bit at address 0x42 clears it. If an event occurs in the same cycle as its clear, the event wins.
- R8: irq_o is 1 exactly when some status bit is set and its mask is set. Control bits 3:1 are the masks for status bits 2:0.
- R9: Addresses 0x00-0x3F read the receive buffer, while writes to them go to the transmit buffer and do not change what is read back. Address 0x40 is control (bit 0 is enable) and 0x41 reads the position.
- R10: While enable (control bit 0) is 0, the position is held at 0, MISO is not driven, and SCLK activity neither stores bytes nor raises events.
- R11: A partial byte cut off by chip select release is discarded and does not move the position.
- R12: With chip select high, miso_o and miso_oe_o are 0 and SCLK toggles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock from the controller |
| cs_n_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller (0 when not driven) |
| miso_oe_o | output | 1 | Output enable for MISO |
| reg_addr_i | input | 7 | Register port address |
| reg_we_i | input | 1 | Register port write strobe |
| reg_wdata_i | input | 8 | Register port write data |
| reg_rdata_o | output | 8 | Register port read data (combinational) |
| irq_o | output | 1 | Interrupt, OR of masked status bits |

## Verification
Two functions can fall in the same cycle:
- a status clear from the register port;
- a buffer event raised by a byte completing on the serial side.

The bench provokes this by holding a write-one-to-clear strobe on the status register for every cycle of a transfer that crosses the half point. In that transfer the half event coincides with a clear. The cycle-accurate reference model expects the event to survive for exactly one cycle. The bench checks this by counting the cycles with irq_o high in that window (exactly one is expected), alongside the per-clock comparison of irq_o, MISO and its enable.

// File: rtl/spi_ct_pkg.sv
package spi_ct_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_XFER = 2'd2
    } ct_state_e;

    localparam int EV_HALF = 0;
    localparam int EV_FULL = 1;
    localparam int EV_END  = 2;
    localparam int EV_N    = 3;
endpackage

// File: rtl/spi_ct_sync.sv
module spi_ct_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/spi_ct_engine.sv
module spi_ct_engine
    import spi_ct_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int DATA_W    = 8,
    localparam int PTR_W    = $clog2(BUF_BYTES),
    localparam int CNT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] tx_word_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              byte_done_o,
    output logic              hit_half_o,
    output logic              hit_wrap_o,
    output logic              xfer_end_o,
    output logic              miso_o,
    output logic              miso_oe_o
);
    localparam logic [PTR_W-1:0] HALF_M1  = PTR_W'(BUF_BYTES / 2 - 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(BUF_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    ct_state_e           state_q, state_d;
    logic                sclk_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [PTR_W-1:0]    ptr_q;
    logic [DATA_W-1:0]   rx_q, tx_q;
    logic                rise, fall, in_xfer;

    assign rise    = sclk_s & ~sclk_d;
    assign fall    = ~sclk_s & sclk_d;
    assign in_xfer = (state_q == ST_XFER);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en_i) state_d = ST_IDLE;
            ST_IDLE: if (!en_i) state_d = ST_OFF;
                     else if (!cs_n_s) state_d = ST_XFER;
            ST_XFER: if (!en_i) state_d = ST_OFF;
                     else if (cs_n_s) state_d = ST_IDLE;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cnt_q  <= '0;
            ptr_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (!en_i) begin
                cnt_q <= '0;
                ptr_q <= '0;
            end else if (state_q == ST_IDLE) begin
                if (!cs_n_s) begin
                    cnt_q <= '0;
                    tx_q  <= tx_word_i;
                end
            end else if (in_xfer) begin
                if (cs_n_s) begin
                    cnt_q <= '0;
                end else if (rise) begin
                    rx_q <= rx_word_o;
                    if (cnt_q == LAST_BIT) begin
                        cnt_q <= '0;
                        ptr_q <= ptr_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else if (fall) begin
                    if (cnt_q == '0) tx_q <= tx_word_i;
                    else             tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_comb begin
        rx_word_o   = {rx_q[DATA_W-2:0], mosi_s};
        byte_done_o = en_i && in_xfer && !cs_n_s && rise && (cnt_q == LAST_BIT);
        hit_half_o  = byte_done_o && (ptr_q == HALF_M1);
        hit_wrap_o  = byte_done_o && (ptr_q == LAST_IDX);
        xfer_end_o  = en_i && in_xfer && cs_n_s;
        miso_oe_o   = in_xfer;
        miso_o      = in_xfer ? tx_q[DATA_W-1] : 1'b0;
        ptr_o       = ptr_q;
    end
endmodule

// File: rtl/spi_ct_events.sv
module spi_ct_events
    import spi_ct_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] set_i,
    input  logic [EV_N-1:0] clr_i,
    input  logic [EV_N-1:0] mask_i,
    output logic [EV_N-1:0] stat_o,
    output logic            irq_o
);
    logic [EV_N-1:0] stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & mask_i);
endmodule

// File: rtl/spi_circ_target.sv
module spi_circ_target
    import spi_ct_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 7,
    localparam int PTR_W    = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BUF_BYTES);
    localparam logic [ADDR_W-1:0] A_POS  = ADDR_W'(BUF_BYTES + 1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BUF_BYTES + 2);

    logic [2:0]        sync_q;
    logic              en_q;
    logic [EV_N-1:0]   mask_q, ev_set, ev_clr, ev_stat;
    logic [DATA_W-1:0] ibuf [BUF_BYTES];
    logic [DATA_W-1:0] obuf [BUF_BYTES];
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] rx_word;
    logic              byte_done, hit_half, hit_wrap, xfer_end, in_buf;

    spi_ct_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({mosi_i, cs_n_i, sclk_i}),
        .q_o   (sync_q)
    );

    spi_ct_engine #(.BUF_BYTES(BUF_BYTES), .DATA_W(DATA_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_q),
        .sclk_s      (sync_q[0]),
        .cs_n_s      (sync_q[1]),
        .mosi_s      (sync_q[2]),
        .tx_word_i   (obuf[ptr_q]),
        .ptr_o       (ptr_q),
        .rx_word_o   (rx_word),
        .byte_done_o (byte_done),
        .hit_half_o  (hit_half),
        .hit_wrap_o  (hit_wrap),
        .xfer_end_o  (xfer_end),
        .miso_o      (miso_o),
        .miso_oe_o   (miso_oe_o)
    );

    assign in_buf = (reg_addr_i < A_CTRL);

    always_comb begin
        ev_set          = '0;
        ev_set[EV_HALF] = hit_half;
        ev_set[EV_FULL] = hit_wrap;
        ev_set[EV_END]  = xfer_end;
        ev_clr = (reg_we_i && reg_addr_i == A_STAT) ? reg_wdata_i[EV_N-1:0] : '0;
    end

    spi_ct_events u_ev (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .clr_i  (ev_clr),
        .mask_i (mask_q),
        .stat_o (ev_stat),
        .irq_o  (irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= '0;
        end else if (reg_we_i && reg_addr_i == A_CTRL) begin
            en_q   <= reg_wdata_i[0];
            mask_q <= reg_wdata_i[EV_N:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_BYTES; i++) begin
                ibuf[i] <= '0;
                obuf[i] <= '0;
            end
        end else begin
            if (byte_done)
                ibuf[ptr_q] <= rx_word;
            if (reg_we_i && in_buf)
                obuf[reg_addr_i[PTR_W-1:0]] <= reg_wdata_i;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (in_buf)                    reg_rdata_o = ibuf[reg_addr_i[PTR_W-1:0]];
        else if (reg_addr_i == A_CTRL) reg_rdata_o = DATA_W'({mask_q, en_q});
        else if (reg_addr_i == A_POS)  reg_rdata_o = DATA_W'(ptr_q);
        else if (reg_addr_i == A_STAT) reg_rdata_o = DATA_W'(ev_stat);
    end
endmodule

// File: rtl/spi_ct_checker.sv
module spi_ct_checker #(
    parameter int BUF_BYTES = 64,
    localparam int PTR_W    = $clog2(BUF_BYTES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [PTR_W-1:0] pos,
    input logic [2:0]       ev,
    input logic             miso_o,
    input logic             miso_oe_o
);
    localparam logic [PTR_W-1:0] HALF = PTR_W'(BUF_BYTES / 2);

    // R12
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe_o |-> !miso_o);

    // R10
    off_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pos == '0));

    // R3
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != $past(pos)) |-> (pos == PTR_W'($past(pos) + 1'b1) || pos == '0));

    // R5
    half_at_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev[0]) |-> (pos == HALF));

    // R5
    full_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev[1]) |-> (pos == '0));

    // R6
    end_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev[2]) |-> ($past(miso_oe_o) && !miso_oe_o));
endmodule

bind spi_circ_target spi_ct_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .pos       (ptr_q),
    .ev        (ev_stat),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o)
);

// File: tb/sim_spi_circ_target.sv
module sim_spi_circ_target;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso, miso_oe, irq;
    logic [6:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    spi_circ_target u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
        .miso_o(miso), .miso_oe_o(miso_oe), .reg_addr_i(reg_addr),
        .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .irq_o(irq)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced once per clock
    int m_state, m_en, m_mask, m_ev, m_ptr, m_cnt, m_rx, m_tx;
    int ibuf_m[64], obuf_m[64];
    int sc1, sc2, sc3, cs1, cs2, mo1, mo2;

    task automatic model_reset();
        m_state = 0; m_en = 0; m_mask = 0; m_ev = 0; m_ptr = 0; m_cnt = 0; m_rx = 0; m_tx = 0;
        for (int i = 0; i < 64; i++) begin ibuf_m[i] = 0; obuf_m[i] = 0; end
        sc1 = 0; sc2 = 0; sc3 = 0; cs1 = 1; cs2 = 1; mo1 = 0; mo2 = 0;
    endtask

    task automatic model_step();
        int set, clr, rise, fall;
        set = 0; clr = 0;
        rise = (sc2 == 1 && sc3 == 0);
        fall = (sc2 == 0 && sc3 == 1);
        if (m_en == 0) begin
            m_state = 0; m_ptr = 0; m_cnt = 0;
        end else if (m_state == 0) begin
            m_state = 1;
        end else if (m_state == 1) begin
            if (cs2 == 0) begin m_state = 2; m_cnt = 0; m_tx = obuf_m[m_ptr]; end
        end else begin
            if (cs2 == 1) begin
                m_state = 1; m_cnt = 0; set |= 4;
            end else if (rise) begin
                m_rx = ((m_rx << 1) | mo2) & 255;
                if (m_cnt == 7) begin
                    ibuf_m[m_ptr] = m_rx;
                    m_ptr = (m_ptr + 1) % 64;
                    if (m_ptr == 32) set |= 1;
                    if (m_ptr == 0) set |= 2;
                    m_cnt = 0;
                end else m_cnt++;
            end else if (fall) begin
                if (m_cnt == 0) m_tx = obuf_m[m_ptr];
                else m_tx = (m_tx << 1) & 255;
            end
        end
        if (reg_we) begin
            if (reg_addr < 64) obuf_m[reg_addr] = reg_wdata;
            if (reg_addr == 64) begin m_en = reg_wdata & 1; m_mask = (reg_wdata >> 1) & 7; end
            if (reg_addr == 66) clr = reg_wdata & 7;
        end
        m_ev = (m_ev & ~clr) | set;
        sc3 = sc2; sc2 = sc1; sc1 = sclk;
        cs2 = cs1; cs1 = cs_n;
        mo2 = mo1; mo1 = mosi;
    endtask

    initial model_reset();
    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // Per-clock comparison of the serial outputs and the interrupt
    bit count_irq = 0;
    int irq_hi = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq == ((m_ev & m_mask) != 0), "R8 irq", irq, (m_ev & m_mask) != 0);
            chk(miso_oe == (m_state == 2), "R12 miso_oe", miso_oe, m_state == 2);
            chk(miso == ((m_state == 2) ? ((m_tx >> 7) & 1) : 0), "R2 miso", miso,
                (m_state == 2) ? ((m_tx >> 7) & 1) : 0);
            if (count_irq && irq) irq_hi++;
        end
    end

    task automatic reg_wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 7'(a); reg_wdata = 8'(d); reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_chk(input int a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = 7'(a);
        #1;
        chk(reg_rdata == 8'(exp), tag, reg_rdata, exp);
    endtask

    task automatic spi_begin();
        @(negedge clk); cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic spi_bits(input int b, input int n);
        for (int i = 0; i < n; i++) begin
            mosi = b[7 - i];
            repeat (8) @(negedge clk);
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic spi_end();
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    function automatic int pat(input int k);
        return (k * 7 + 3) & 255;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_chk(64, 0, "R1 ctrl");
        reg_chk(65, 0, "R1 pos");
        reg_chk(66, 0, "R1 status");
        chk(irq == 0 && miso_oe == 0, "R1 outputs", {irq, miso_oe}, 0);

        for (int i = 0; i < 64; i++) reg_wr(i, (i * 37 + 11) & 255);
        // R9 writes to buffer addresses land in transmit side only
        reg_chk(3, 0, "R9 rx readback unaffected");
        reg_wr(64, 8'h0F);
        reg_chk(64, 8'h0F, "R9 ctrl readback");

        // R2 R3 five-byte transfer
        spi_begin();
        for (int k = 0; k < 5; k++) spi_bits(pat(k), 8);
        spi_end();
        reg_chk(65, 5, "R3 pos after 5 bytes");
        for (int k = 0; k < 5; k++) reg_chk(k, pat(k), "R3 stored byte");
        reg_chk(66, 4, "R6 end event");
        reg_wr(66, 4);
        reg_chk(66, 0, "R7 w1c clear");

        // R11 partial byte
        spi_begin();
        spi_bits(8'hF0, 3);
        spi_end();
        reg_chk(65, 5, "R11 pos unchanged");
        reg_chk(5, ibuf_m[5], "R11 no store");
        reg_chk(66, 4, "R6 end after partial");
        reg_wr(66, 7);

        // R4 R5 long transfer with half mask off
        reg_wr(64, 8'h0D);
        spi_begin();
        for (int k = 0; k < 70; k++) spi_bits(pat(k), 8);
        spi_end();
        reg_chk(65, 11, "R4 pos after wrap");
        reg_chk(10, pat(69), "R4 last byte");
        reg_chk(4, pat(63), "R4 overwrite");
        reg_chk(66, 7, "R5 half+full+end");
        reg_wr(66, 7);
        reg_wr(64, 8'h0F);

        // R7 clear held while the half event fires
        @(negedge clk);
        reg_addr = 7'd66; reg_wdata = 8'h07; reg_we = 1'b1;
        irq_hi = 0; count_irq = 1;
        spi_begin();
        for (int k = 0; k < 25; k++) spi_bits(pat(k + 100), 8);
        count_irq = 0;
        @(negedge clk); reg_we = 1'b0;
        chk(irq_hi == 1, "R7 set wins over clear", irq_hi, 1);
        spi_end();
        reg_chk(65, 36, "R3 pos 36");
        reg_chk(66, 4, "R7 only end left");
        reg_wr(66, 7);

        // R12 SCLK toggles with chip select high
        spi_bits(8'hAA, 4);
        reg_chk(65, 36, "R12 pos unchanged");
        reg_chk(66, 0, "R12 no event");

        // R10 disabled
        reg_wr(64, 8'h0E);
        reg_chk(65, 0, "R10 pos cleared");
        spi_begin();
        spi_bits(8'h5A, 8);
        spi_bits(8'hC3, 8);
        spi_end();
        reg_chk(65, 0, "R10 pos held");
        reg_chk(0, pat(59), "R10 no store");
        reg_chk(66, 0, "R10 no event");

        // re-enable, one byte at position 0
        reg_wr(64, 8'h0F);
        spi_begin();
        spi_bits(8'h96, 8);
        spi_end();
        reg_chk(0, 8'h96, "R3 byte at 0");
        reg_chk(65, 1, "R3 pos 1");
        reg_chk(66, 4, "R6 end event again");

        done = 1;
        summary();
        $finish;
    end
endmodule